// File: doc/BRIEF.md
# Target Write Burst Segmenter

The block sits between a bus target that delivers write data and an internal memory command bus. Each accepted beat is one 32-bit dword with four byte enables. The first beat of a transaction carries the starting dword address, and later beats follow at consecutive addresses. The block stores the data in a write buffer. It cuts the stream into memory write commands of two kinds: bursts of up to 16 dwords in which every byte lane is enabled, and masked writes of one dword that carry their byte mask.

A command is offered on the command port only after the buffer holds every dword that command will move. The command port uses a valid/ready pair, where ready plays the part of the bus grant. After a command is granted, the memory side pulls its data one dword per pull strobe, in command order. Data therefore streams on every clock once a transfer starts. The write buffer never overflows, because the block withdraws its input ready when the buffer or the command queue lacks room.

A typical case is a misaligned 68-byte write starting at byte address 0x2. It produces three commands. The first is a masked write of dword 0 with lanes 3:2 enabled. The second is a 16-dword burst from dword 1. The third is a masked write of dword 17 with lanes 1:0 enabled.

Top module: `tgt_burst_segmenter`

## Requirements
- R1: After reset, cmd_valid and wr_valid are 0 and in_ready is 1.
- R2: Consecutive beats with in_be == 4'b1111 are merged into one burst command. The burst has cmd_masked = 0, cmd_mask = 4'b1111, cmd_addr equal to the dword address of its first beat, and cmd_len equal to the dword count minus one.
- R3: A burst is closed when it reaches 16 dwords or when a beat with in_last is accepted, whichever comes first. Dwords that follow the limit start a new burst.
- R4: A beat whose in_be is neither 4'b0000 nor 4'b1111 first closes any open burst, which is issued before it. The beat then becomes its own command with cmd_masked = 1, cmd_len = 0, cmd_mask = in_be and cmd_addr equal to its dword address.
- R5: A beat with in_be == 4'b0000 is neither stored nor written, and it produces no command. It still advances the dword address and closes any open burst.
- R6: No command is offered while any dword of that command is still missing from the buffer. In particular, a burst that is still open is never offered.
- R7: While cmd_valid is 1 and cmd_ready is 0, cmd_valid and all command fields hold their values.
- R8: wr_valid is asserted only in a cycle where pull_valid is 1 and some granted dword is still unpulled. The write data comes out in the order in which the dwords were accepted.
- R9: in_ready drops to 0 when the 32-dword buffer is full. No accepted dword is lost or duplicated, and every enabled byte is written exactly once.
- R10: A transaction starting at dword 0 is handled as follows. It consists of one beat with enables 4'b1100, then 16 full beats, then a last beat with enables 4'b0011. It yields three commands in this order: masked at dword 0 with mask 4'b1100, burst at dword 1 with length code 15, and masked at dword 17 with mask 4'b0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Target beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_first | input | 1 | Beat is the first of a transaction (in_addr valid) |
| in_last | input | 1 | Beat is the last of a transaction |
| in_addr | input | 16 | Starting dword address, used on the first beat |
| in_data | input | 32 | Write dword |
| in_be | input | 4 | Byte enables, bit i for byte lane i |
| cmd_valid | output | 1 | Memory write command offered |
| cmd_ready | input | 1 | Command bus grant |
| cmd_addr | output | 16 | Command dword address |
| cmd_len | output | 4 | Dword count minus one |
| cmd_masked | output | 1 | Masked single-dword write |
| cmd_mask | output | 4 | Byte mask (all ones for bursts) |
| pull_valid | input | 1 | Memory side pulls one dword |
| wr_valid | output | 1 | Write dword presented for this pull |
| wr_data | output | 32 | Pulled write dword |

## Verification
The bench aims at the points where segment boundaries are easy to get wrong. These are a partial or empty beat inside a run of full beats, the 16-dword limit inside a long transaction, and a partial first or last beat on a misaligned start. A design that got these wrong would emit a burst carrying a partial mask, a masked write longer than one dword, or commands with shifted addresses. It also holds an unfinished burst open for many cycles and checks that nothing is offered early. It stalls the grant with a full buffer to check that in_ready falls at exactly 32 dwords. It checks that pulls with no granted command return nothing, since a faulty design would replay stale data there.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int MASK_W    = DATA_W / 8;
  localparam int MAX_BURST = 16;
  localparam int LEN_W     = $clog2(MAX_BURST);
  localparam int CNT_W     = LEN_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              masked;
    logic [MASK_W-1:0] mask;
  } wcmd_t;

  // dword count to length code (count minus one)
  function automatic logic [LEN_W-1:0] len_code(input logic [CNT_W-1:0] cnt);
    return LEN_W'(cnt - CNT_W'(1));
  endfunction

  function automatic logic lanes_full(input logic [MASK_W-1:0] be);
    return &be;
  endfunction

  function automatic logic lanes_none(input logic [MASK_W-1:0] be);
    return ~|be;
  endfunction

  function automatic wcmd_t mk_burst(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] cnt);
    wcmd_t c;
    c.addr = a; c.len = len_code(cnt); c.masked = 1'b0; c.mask = '1;
    return c;
  endfunction

  function automatic wcmd_t mk_single(input logic [ADDR_W-1:0] a, input logic [MASK_W-1:0] be);
    wcmd_t c;
    c.addr = a; c.len = '0; c.masked = 1'b1; c.mask = be;
    return c;
  endfunction
endpackage

// File: rtl/tbs_data_buf.sv
module tbs_data_buf #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full
);
  localparam int PW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;

  assign dout = mem[rptr];
  assign full = (count == (PW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + PW'(1);
      if (pop)  rptr <= rptr + PW'(1);
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < (PW+1)'(DEPTH)));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/tbs_cmd_queue.sv
module tbs_cmd_queue
  import tbs_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_a,
  input  wcmd_t cmd_a,
  input  logic  push_b,
  input  wcmd_t cmd_b,
  input  logic  pop,
  output wcmd_t head,
  output logic  avail,
  output logic  room2
);
  localparam int PW = $clog2(DEPTH);

  wcmd_t         mem [DEPTH];
  logic [PW-1:0] wptr, rptr, wptr_b;
  logic [PW:0]   count;
  logic [PW:0]   ins;

  assign head   = mem[rptr];
  assign avail  = (count != '0);
  assign room2  = (count <= (PW+1)'(DEPTH - 2));
  assign wptr_b = push_a ? wptr + PW'(1) : wptr;
  assign ins    = (PW+1)'(push_a) + (PW+1)'(push_b);

  // entry a (the closed burst) always lands before entry b
  always_ff @(posedge clk) begin
    if (push_a) mem[wptr]   <= cmd_a;
    if (push_b) mem[wptr_b] <= cmd_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + PW'(ins);
      if (pop) rptr <= rptr + PW'(1);
      count <= count + ins - (PW+1)'(pop);
    end
  end

  // R9
  q_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_a || push_b) |-> (count + ins <= (PW+1)'(DEPTH)));
endmodule

// File: rtl/tbs_seg_track.sv
module tbs_seg_track
  import tbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              first,
  input  logic              last,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MASK_W-1:0] be,
  output logic              push_a,
  output wcmd_t             cmd_a,
  output logic              push_b,
  output wcmd_t             cmd_b,
  output logic              store
);
  logic              open;
  logic [CNT_W-1:0]  open_cnt;
  logic [ADDR_W-1:0] open_addr, next_addr;

  logic [ADDR_W-1:0] beat_addr, run_addr;
  logic [CNT_W-1:0]  run_cnt;
  logic              full_be, none_be, run_close;

  always_comb begin
    beat_addr = first ? addr : next_addr;
    full_be   = lanes_full(be);
    none_be   = lanes_none(be);
    run_cnt   = (open ? open_cnt : '0) + CNT_W'(1);
    run_addr  = open ? open_addr : beat_addr;
    run_close = (run_cnt == CNT_W'(MAX_BURST)) || last;
    push_a    = 1'b0;
    push_b    = 1'b0;
    cmd_a     = mk_burst(open_addr, open_cnt);
    cmd_b     = mk_single(beat_addr, be);
    if (fire) begin
      if (full_be) begin
        if (run_close) begin
          push_a = 1'b1;
          cmd_a  = mk_burst(run_addr, run_cnt);
        end
      end else begin
        push_a = open;
        push_b = !none_be;
      end
    end
  end

  assign store = fire && !none_be;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open      <= 1'b0;
      open_cnt  <= '0;
      open_addr <= '0;
      next_addr <= '0;
    end else if (fire) begin
      next_addr <= beat_addr + ADDR_W'(1);
      if (full_be && !run_close) begin
        open      <= 1'b1;
        open_cnt  <= run_cnt;
        open_addr <= run_addr;
      end else begin
        open      <= 1'b0;
        open_cnt  <= '0;
      end
    end
  end

  // R3
  open_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> (open_cnt != '0) && (open_cnt < CNT_W'(MAX_BURST)));
endmodule

// File: rtl/tgt_burst_segmenter.sv
module tgt_burst_segmenter
  import tbs_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int Q_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [MASK_W-1:0] in_be,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_masked,
  output logic [MASK_W-1:0] cmd_mask,
  input  logic              pull_valid,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CW = $clog2(BUF_DEPTH) + 1;

  logic          in_fire, cmd_fire, store;
  logic          push_a, push_b, q_room2, buf_full;
  wcmd_t         cmd_a, cmd_b, head;
  logic [CW-1:0] buf_count, credit, grant_words;

  assign in_ready = !buf_full && q_room2;
  assign in_fire  = in_valid && in_ready;
  assign cmd_fire = cmd_valid && cmd_ready;

  tbs_seg_track u_seg (
    .clk(clk), .rst_n(rst_n), .fire(in_fire), .first(in_first), .last(in_last),
    .addr(in_addr), .be(in_be), .push_a(push_a), .cmd_a(cmd_a),
    .push_b(push_b), .cmd_b(cmd_b), .store(store)
  );

  tbs_cmd_queue #(.DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push_a(push_a), .cmd_a(cmd_a),
    .push_b(push_b), .cmd_b(cmd_b), .pop(cmd_fire), .head(head),
    .avail(cmd_valid), .room2(q_room2)
  );

  tbs_data_buf #(.DEPTH(BUF_DEPTH), .WIDTH(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(store), .din(in_data), .pop(wr_valid),
    .dout(wr_data), .count(buf_count), .full(buf_full)
  );

  assign cmd_addr   = head.addr;
  assign cmd_len    = head.len;
  assign cmd_masked = head.masked;
  assign cmd_mask   = head.mask;

  // granted but not yet pulled dwords
  assign grant_words = cmd_fire ? CW'(cmd_len) + CW'(1) : '0;
  assign wr_valid    = pull_valid && (credit != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) credit <= '0;
    else        credit <= credit + grant_words - CW'(wr_valid);
  end

  // R6
  data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ({1'b0, buf_count} >= {1'b0, credit} + (CW+1)'(cmd_len) + (CW+1)'(1)));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(head)));

  // R4
  masked_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_masked) |-> (cmd_len == '0));

  // R2
  burst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_masked) |-> (&cmd_mask));
endmodule

// File: tb/test_tgt_burst_segmenter.sv
module test_tgt_burst_segmenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [15:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_be = '0;
  logic        in_ready, cmd_valid, cmd_masked, wr_valid;
  logic        cmd_ready = 1'b0, pull_valid = 1'b0;
  logic [15:0] cmd_addr;
  logic [3:0]  cmd_len, cmd_mask;
  logic [31:0] wr_data;

  tgt_burst_segmenter i_tgt_burst_segmenter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_addr(in_addr), .in_data(in_data),
    .in_be(in_be), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_masked(cmd_masked), .cmd_mask(cmd_mask),
    .pull_valid(pull_valid), .wr_valid(wr_valid), .wr_data(wr_data)
  );

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  int accepted = 0;
  int mode = 0;          // 0 hold, 1 random, 2 always on
  bit manual_cmds = 0;
  string tag_ovr = "";
  logic [24:0] exp_cmd [$];
  logic [31:0] exp_dat [$];

  // bench reference state
  logic [15:0] m_next, m_start;
  int          m_cnt = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] pack_cmd(logic [15:0] a, logic [3:0] l, logic m, logic [3:0] k);
    return {a, l, m, k};
  endfunction

  task automatic model_beat(logic first, logic last, logic [15:0] addr, logic [3:0] be, logic [31:0] d);
    logic [15:0] here;
    if (first) m_next = addr;
    here = m_next;
    m_next = m_next + 16'd1;
    if (be == 4'hF) begin
      if (m_cnt == 0) m_start = here;
      m_cnt++;
      exp_dat.push_back(d);
      if (m_cnt == 16 || last) begin
        if (!manual_cmds) exp_cmd.push_back(pack_cmd(m_start, 4'(m_cnt - 1), 1'b0, 4'hF));
        m_cnt = 0;
      end
    end else begin
      if (m_cnt > 0 && !manual_cmds) exp_cmd.push_back(pack_cmd(m_start, 4'(m_cnt - 1), 1'b0, 4'hF));
      m_cnt = 0;
      if (be != 4'h0) begin
        exp_dat.push_back(d);
        if (!manual_cmds) exp_cmd.push_back(pack_cmd(here, 4'd0, 1'b1, be));
      end
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic send_beat(logic first, logic last, logic [15:0] addr, logic [3:0] be, logic [31:0] d);
    in_valid = 1'b1; in_first = first; in_last = last; in_addr = addr; in_be = be; in_data = d;
    while (!in_ready) @(negedge clk);
    model_beat(first, last, addr, be, d);
    accepted++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer side and output comparison
  bit          hold_pend = 0;
  logic [25:0] held;
  always @(negedge clk) begin
    case (mode)
      1: begin cmd_ready = ($urandom % 3) != 0; pull_valid = ($urandom % 4) != 0; end
      2: begin cmd_ready = 1'b1; pull_valid = 1'b1; end
      default: begin cmd_ready = 1'b0; pull_valid = (mode == 3); end
    endcase
    #1;
    if (rst_n) begin
      if (hold_pend)
        check("R7 command held while not granted",
              {cmd_valid, cmd_addr, cmd_len, cmd_masked, cmd_mask}, held);
      if (cmd_valid && cmd_ready) begin
        if (exp_cmd.size() == 0)
          check("R6 unexpected command", 1, 0);
        else
          check(tag_ovr != "" ? tag_ovr : (cmd_masked ? "R4 masked command" : "R2 R3 burst command"),
                pack_cmd(cmd_addr, cmd_len, cmd_masked, cmd_mask), exp_cmd.pop_front());
      end
      hold_pend = cmd_valid && !cmd_ready;
      held = {cmd_valid, cmd_addr, cmd_len, cmd_masked, cmd_mask};
      if (wr_valid) begin
        if (exp_dat.size() == 0) check("R8 unexpected write data", 1, 0);
        else check("R8 R9 write data order", wr_data, exp_dat.pop_front());
      end
    end
  end

  task automatic wait_drain();
    int n = 0;
    while ((exp_cmd.size() != 0 || exp_dat.size() != 0) && n < 4000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1
    check("R1 reset cmd_valid", cmd_valid, 0);
    check("R1 reset wr_valid", wr_valid, 0);
    check("R1 reset in_ready", in_ready, 1);

    // R8: pulls with nothing granted return nothing
    mode = 3;
    repeat (3) @(negedge clk);
    #2;
    check("R8 pull without grant", wr_valid, 0);
    mode = 0;
    @(negedge clk);

    // R10: misaligned 68-byte example
    manual_cmds = 1;
    exp_cmd.push_back(pack_cmd(16'd0, 4'd0, 1'b1, 4'b1100));
    exp_cmd.push_back(pack_cmd(16'd1, 4'd15, 1'b0, 4'hF));
    exp_cmd.push_back(pack_cmd(16'd17, 4'd0, 1'b1, 4'b0011));
    send_beat(1, 0, 16'd0, 4'b1100, 32'hA000_0000);
    for (int i = 0; i < 16; i++) send_beat(0, 0, 16'd0, 4'hF, 32'hA000_0001 + 32'(i));
    send_beat(0, 1, 16'd0, 4'b0011, 32'hA000_0011);
    manual_cmds = 0;
    tag_ovr = "R10";
    mode = 2;
    wait_drain();
    tag_ovr = "";
    check("R10 all example commands issued", exp_cmd.size(), 0);

    // R6: an open burst is not offered
    for (int i = 0; i < 10; i++) send_beat(i == 0, 0, 16'h0100, 4'hF, 32'hB000_0000 + 32'(i));
    repeat (20) @(negedge clk);
    #2;
    check("R6 open burst not offered", cmd_valid, 0);
    check("R6 no data before command", wr_valid, 0);
    send_beat(0, 1, 16'd0, 4'hF, 32'hB000_000A);
    wait_drain();

    // R5: empty beat splits a run and writes nothing
    send_beat(1, 0, 16'h0200, 4'hF, 32'hC000_0000);
    send_beat(0, 0, 16'd0, 4'hF, 32'hC000_0001);
    send_beat(0, 0, 16'd0, 4'h0, 32'hDEAD_BEEF);
    send_beat(0, 1, 16'd0, 4'hF, 32'hC000_0003);
    check("R5 expected burst after gap", exp_cmd.size() != 0 ? exp_cmd[$] : '0,
          pack_cmd(16'h0203, 4'd0, 1'b0, 4'hF));
    wait_drain();

    // R4: partial beat in the middle of a run
    send_beat(1, 0, 16'h0300, 4'hF, 32'hD000_0000);
    send_beat(0, 0, 16'd0, 4'b0101, 32'hD000_0001);
    send_beat(0, 1, 16'd0, 4'hF, 32'hD000_0002);
    wait_drain();

    // R9: backpressure at a full buffer
    mode = 0;
    accepted = 0;
    fork
      for (int i = 0; i < 40; i++) send_beat(i == 0, i == 39, 16'h0400, 4'hF, 32'hE000_0000 + 32'(i));
      begin
        repeat (60) @(negedge clk);
        #2;
        check("R9 accepted before stall", accepted, 32);
        check("R9 in_ready low when full", in_ready, 0);
        mode = 1;
      end
    join
    wait_drain();

    // random traffic, fixed seed
    void'($urandom(32'h5EED_1234));
    mode = 1;
    for (int t = 0; t < 40; t++) begin
      int len = 1 + ($urandom % 40);
      logic [15:0] base = 16'($urandom);
      for (int b = 0; b < len; b++) begin
        int r = $urandom % 10;
        logic [3:0] be = (r < 7) ? 4'hF : (r == 7) ? 4'h0 : 4'(1 + ($urandom % 14));
        send_beat(b == 0, b == len - 1, base, be, $urandom);
      end
      if (($urandom % 4) == 0) repeat ($urandom % 8) @(negedge clk);
    end
    wait_drain();
    check("R2 R3 R4 all commands seen", exp_cmd.size(), 0);
    check("R9 every stored dword written once", exp_dat.size(), 0);
    finish_run();
  end
endmodule